// File: doc/BRIEF.md
# Wake-on-Motion Threshold Detector

This block watches a stream of three-axis accelerometer samples and raises a wake interrupt when the sample moves far enough from the one before it. Each new sample is compared, axis by axis, with the sample stored on the previous strobe. An axis counts as moved when the absolute change is strictly larger than that axis's threshold. The threshold is an 8-bit code, shifted left by a parameterized amount (default 2, so one code step is four sample LSBs).

The per-axis results are then merged. Only axes whose enable bit is set take part. A combine-mode input chooses between two rules: fire when any enabled axis moved, or fire only when every enabled axis moved. A master enable gates the whole detector. Whenever that enable is low, the stored sample is forgotten, so the first sample after it rises only primes the history.

The interrupt is a registered single-clock pulse. It appears in the clock cycle that follows the accepted sample strobe.

Top module: `wom_detector`

## Requirements
- R1: While `wom_en` is low, `wom_irq` stays low whatever arrives on the sample inputs, and the stored history is discarded.
- R2: The first `smp_valid` strobe accepted after `wom_en` rises (or after reset) only stores the sample and never produces a pulse.
- R3: An axis is hit when |current − previous| > (threshold << 2). The difference is formed at 17 bits, so a swing from −32768 to +32767, or back, is measured correctly. A change exactly equal to the scaled threshold is not a hit.
- R4: With `and_mode` = 0, the pulse fires when at least one enabled axis is hit.
- R5: With `and_mode` = 1, the pulse fires only when every enabled axis is hit.
- R6: An axis whose bit in `axis_en` is 0 is ignored by both rules. With `axis_en` = 0, `wom_irq` stays low.
- R7: `wom_irq` is high for exactly the one cycle after the qualifying strobe, and it is low in any cycle that does not follow an accepted strobe.
- R8: Every accepted strobe while enabled replaces the stored sample, including a strobe that fires the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wom_en | input | 1 | Master enable of the detector |
| and_mode | input | 1 | Combine rule: 0 = any enabled axis, 1 = all enabled axes |
| axis_en | input | 3 | Per-axis participation; bit 0 = X, bit 1 = Y, bit 2 = Z |
| axis_thresh | input | 24 | Per-axis 8-bit threshold codes; bits [8a+7:8a] belong to axis a |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | 48 | Signed 16-bit samples; bits [16a+15:16a] belong to axis a |
| wom_irq | output | 1 | Wake-on-motion pulse, one clock wide |

## Verification
Two events can land on the same strobe: the priming of the history and a change large enough to fire. The bench provokes this by reopening the detector before every vector and presenting, as the first sample, a value far from whatever was stored before. No pulse is allowed to follow it. A second overlap is a firing sample that also becomes the new reference. The bench follows a firing strobe with a repeat of the same value and expects silence, then adds a fresh jump and expects a pulse. All verdicts come from arithmetic on the applied values, swept over every axis-enable mask, both combine rules and every hit pattern. The changes sit exactly at the scaled threshold or one LSB above it.

// File: rtl/wom_pkg.sv
package wom_pkg;

    typedef enum logic {
        COMB_ANY = 1'b0,
        COMB_ALL = 1'b1
    } comb_mode_e;

endpackage

// File: rtl/wom_axis_cmp.sv
module wom_axis_cmp #(
    parameter int SAMPLE_W = 16,
    parameter int TH_W     = 8,
    parameter int TH_SHIFT = 2
) (
    input  logic [SAMPLE_W-1:0] cur_i,
    input  logic [SAMPLE_W-1:0] prev_i,
    input  logic [TH_W-1:0]     thresh_i,
    output logic                hit_o
);
    localparam int DW = SAMPLE_W + 1;

    logic [DW-1:0] cur_x;
    logic [DW-1:0] prev_x;
    logic [DW-1:0] diff;
    logic [DW-1:0] mag;
    logic [DW-1:0] limit;

    always_comb begin
        cur_x  = {cur_i[SAMPLE_W-1], cur_i};
        prev_x = {prev_i[SAMPLE_W-1], prev_i};
        diff   = cur_x - prev_x;
        mag    = diff[DW-1] ? (~diff + 1'b1) : diff;
        limit  = {{(DW-TH_W){1'b0}}, thresh_i} << TH_SHIFT;
        hit_o  = mag > limit;
    end

    // R3: the magnitude can never exceed the span of two extreme samples
    always_comb begin
        a_r3_mag_in_span: assert (mag <= {1'b0, {SAMPLE_W{1'b1}}});
    end

endmodule

// File: rtl/wom_combine.sv
module wom_combine
    import wom_pkg::*;
#(
    parameter int AXES = 3
) (
    input  logic [AXES-1:0] hit_i,
    input  logic [AXES-1:0] en_i,
    input  comb_mode_e      mode_i,
    output logic            fire_o
);
    logic [AXES-1:0] any_term;
    logic [AXES-1:0] all_term;
    logic            any_fire;
    logic            all_fire;

    for (genvar a = 0; a < AXES; a++) begin : g_term
        assign any_term[a] = hit_i[a] & en_i[a];
        assign all_term[a] = hit_i[a] | ~en_i[a];
    end

    always_comb begin
        any_fire = |any_term;
        all_fire = (|en_i) & (&all_term);
        fire_o   = (mode_i == COMB_ALL) ? all_fire : any_fire;
    end

    // R5: the all-axes rule is never looser than the any-axis rule
    always_comb begin
        if (all_fire) begin
            a_r5_all_within_any: assert (any_fire);
        end
    end

endmodule

// File: rtl/wom_detector.sv
module wom_detector
    import wom_pkg::*;
#(
    parameter int AXES     = 3,
    parameter int SAMPLE_W = 16,
    parameter int TH_W     = 8,
    parameter int TH_SHIFT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wom_en,
    input  logic                     and_mode,
    input  logic [AXES-1:0]          axis_en,
    input  logic [AXES*TH_W-1:0]     axis_thresh,
    input  logic                     smp_valid,
    input  logic [AXES*SAMPLE_W-1:0] smp_data,
    output logic                     wom_irq
);
    typedef struct packed {
        logic                          armed;
        logic [AXES-1:0][SAMPLE_W-1:0] prev;
        logic                          irq;
    } state_t;

    state_t st_d, st_q;

    logic [AXES-1:0] axis_hit;
    logic            fire;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        wom_axis_cmp #(
            .SAMPLE_W (SAMPLE_W),
            .TH_W     (TH_W),
            .TH_SHIFT (TH_SHIFT)
        ) cmp_i (
            .cur_i    (smp_data[a*SAMPLE_W +: SAMPLE_W]),
            .prev_i   (st_q.prev[a]),
            .thresh_i (axis_thresh[a*TH_W +: TH_W]),
            .hit_o    (axis_hit[a])
        );
    end

    wom_combine #(
        .AXES (AXES)
    ) comb_i (
        .hit_i  (axis_hit),
        .en_i   (axis_en),
        .mode_i (comb_mode_e'(and_mode)),
        .fire_o (fire)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!wom_en) begin
            st_d.armed = 1'b0;
        end else if (smp_valid) begin
            st_d.prev  = smp_data;
            st_d.armed = 1'b1;
            st_d.irq   = st_q.armed & fire;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wom_irq = st_q.irq;

    // R1: a disabled detector is silent
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !wom_en |=> !wom_irq);

    // R2: the priming strobe never fires
    a_r2_prime_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (wom_en && smp_valid && !st_q.armed) |=> !wom_irq);

    // R6: with no axis selected nothing fires
    a_r6_no_axis_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (axis_en == '0) |=> !wom_irq);

    // R7: every pulse follows an accepted strobe
    a_r7_pulse_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wom_irq |-> $past(smp_valid && wom_en));

    // R8: an accepted strobe leaves the detector armed
    a_r8_armed_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (wom_en && smp_valid) |=> st_q.armed);

endmodule

// File: tb/wom_detector_tb_top.sv
module wom_detector_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wom_en = 1'b0;
    logic        and_mode = 1'b0;
    logic [2:0]  axis_en = '0;
    logic [23:0] axis_thresh = '0;
    logic        smp_valid = 1'b0;
    logic [47:0] smp_data = '0;
    logic        wom_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wom_detector dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wom_en      (wom_en),
        .and_mode    (and_mode),
        .axis_en     (axis_en),
        .axis_thresh (axis_thresh),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .wom_irq     (wom_irq)
    );

    task automatic check(input logic exp, input string req);
        n_chk++;
        if (wom_irq !== exp) begin
            n_bad++;
            $display("FAIL %s: wom_irq=%0b expected %0b", req, wom_irq, exp);
        end
    endtask

    task automatic set_smp(input int x, input int y, input int z);
        smp_data[15:0]  = 16'(x);
        smp_data[31:16] = 16'(y);
        smp_data[47:32] = 16'(z);
    endtask

    // one strobe: drive after negedge, observe after the next rising edge
    task automatic strobe(input int x, input int y, input int z, input logic exp, input string req);
        @(negedge clk);
        set_smp(x, y, z);
        smp_valid = 1'b1;
        @(posedge clk);
        #1;
        check(exp, req);
        @(negedge clk);
        smp_valid = 1'b0;
        @(posedge clk);
        #1;
        check(1'b0, "R7");
    endtask

    task automatic reopen();
        @(negedge clk);
        wom_en = 1'b0;
        @(negedge clk);
        wom_en = 1'b1;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lim[3];
        int base[3];
        int nxt[3];
        axis_thresh = {8'd200, 8'd37, 8'd10};
        lim[0] = 40; lim[1] = 148; lim[2] = 800;
        base[0] = -3000; base[1] = 500; base[2] = 7000;
        repeat (3) @(posedge clk);
        #1;
        check(1'b0, "R7 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // sweep: enable masks x combine rule x hit pattern
        for (int m = 0; m < 8; m++) begin
            for (int md = 0; md < 2; md++) begin
                for (int h = 0; h < 8; h++) begin
                    logic exp;
                    reopen();
                    axis_en  = 3'(m);
                    and_mode = md[0];
                    for (int a = 0; a < 3; a++) begin
                        int step;
                        step = lim[a] + ((h >> a) & 1);
                        nxt[a] = (((h + a) % 2) == 1) ? base[a] - step : base[a] + step;
                    end
                    // R2: priming strobe far from old history stays silent
                    strobe(base[0], base[1], base[2], 1'b0, "R2");
                    if (md == 0) exp = ((h & m) != 0);
                    else         exp = (m != 0) && ((h & m) == m);
                    // R3 R4 R5 R6
                    strobe(nxt[0], nxt[1], nxt[2], exp,
                           md == 0 ? "R4/R3/R6" : "R5/R3/R6");
                end
            end
        end

        // R3 extremes
        reopen();
        axis_thresh = {3{8'd255}};
        axis_en = 3'b111;
        and_mode = 1'b1;
        strobe(-32768, -32768, -32768, 1'b0, "R2");
        strobe(32767, 32767, 32767, 1'b1, "R3 up");
        strobe(-32768, -32768, -32768, 1'b1, "R3 down");

        // R8: history follows each strobe, including a firing one
        strobe(-32768, -32768, -32768, 1'b0, "R8 repeat");
        strobe(-31747, -31747, -31747, 1'b1, "R8 jump");
        strobe(-31747, -31747, -31747, 1'b0, "R8 repeat2");

        // R1: disabled, large swings produce nothing
        @(negedge clk);
        wom_en = 1'b0;
        strobe(32767, 32767, 32767, 1'b0, "R1");
        strobe(-32768, -32768, -32768, 1'b0, "R1");
        // R1: history discarded, first strobe after re-enable only primes
        @(negedge clk);
        wom_en = 1'b1;
        strobe(32767, 32767, 32767, 1'b0, "R1 R2");
        strobe(-32768, -32768, -32768, 1'b1, "R1 rearmed");

        // R1: enable dropped on the same cycle as a strobe
        @(negedge clk);
        set_smp(32767, 32767, 32767);
        smp_valid = 1'b1;
        wom_en = 1'b0;
        @(posedge clk);
        #1;
        check(1'b0, "R1 same cycle");
        @(negedge clk);
        smp_valid = 1'b0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule